// File: doc/BRIEF.md
# Datapath Lockup Watchdog

This block watches four engines of an Ethernet controller: transmit DMA, transmit MAC, receive DMA and receive MAC. It reports any engine that stays busy too long without making progress. Each engine supplies a busy level and a one-cycle progress pulse. One free-running prescaler, clocked by the transmit clock, produces a tick every programmed number of cycles. Each monitor has a counter that advances on those ticks while its engine is enabled, busy and making no progress. When that counter reaches its timeout, the monitor raises a sticky lockup flag.

A single 32-bit configuration word holds everything software controls. It has four monitor enables, a recovery enable, one timeout shared by the two DMA monitors, and the prescaler. The two MAC monitors take their timeout from an input port, which is fed from a register elsewhere. When recovery is on, a newly raised lockup flag also produces a one-cycle request that forces the MAC into reset.

Top module: `lockup_watchdog`

## Requirements
- R1: After reset the configuration reads 0x07FFFFFF, so all four monitors are off, recovery is off, the DMA timeout is 0x7FF and the prescaler is 0xFFFF. All lockup flags and the reset request are low.
- R2: A write stores all 32 bits on the clock edge where `cfg_wr_en` is high, and `cfg_rd_data` shows the stored word from the next cycle on. Without a write, the word never changes.
- R3: Enable bits map to monitors as follows: bit 31 to transmit DMA (`lock_flag[3]`), bit 30 to transmit MAC (`lock_flag[2]`), bit 29 to receive DMA (`lock_flag[1]`) and bit 28 to receive MAC (`lock_flag[0]`). A disabled monitor never raises its flag.
- R4: The prescaler field P (bits 15:0) sets a tick period of P clock cycles, and a value of 0 or 1 gives a tick every cycle. The DMA timeout field T (bits 26:16) applies to indices 3 and 1. After a configuration write at edge E0, an engine that stays busy raises its flag exactly at edge E0 + T*P.
- R5: The MAC monitors (indices 2 and 0) use `mac_timeout` in place of the DMA field, with the same tick timing.
- R6: A progress pulse, or one idle cycle (busy low), clears that monitor's counter and restarts the full timeout. The prescaler keeps running through it.
- R7: A timeout of zero never raises a flag, however long the engine stays busy.
- R8: A flag stays high until `lock_clr` for its index is high at a clock edge, and clear wins over a new detection. The counter restarts at detection, so a stall that persists raises the flag again one full timeout after the previous detection.
- R9: With bit 27 set, each edge where any flag goes from low to high drives `mac_reset_req` high for exactly that one following cycle. With bit 27 clear, the request stays low.
- R10: A write that changes any of bits 26:0 restarts the prescaler and all monitor counters at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Current configuration word |
| mac_timeout | input | 16 | Timeout in ticks for the two MAC monitors |
| busy | input | 4 | Engine busy levels, index 3..0 = tx DMA, tx MAC, rx DMA, rx MAC |
| progress | input | 4 | One-cycle progress pulses, same indexing |
| lock_clr | input | 4 | Per-flag clear, same indexing |
| lock_flag | output | 4 | Sticky lockup flags, same indexing |
| mac_reset_req | output | 1 | One-cycle MAC reset request |

## Verification
Each directed scenario starts with a fresh configuration write, and the bench samples the flag one edge before and on the exact predicted edge. This separates the correct detection time from a timeout that is off by one tick or one cycle. Several stall patterns are used: an uninterrupted stall, a stall cut by a progress pulse, a stall cut by one idle cycle, and a stall during which the configuration is rewritten. Together they show that a counter restart comes only from progress, idle or a configuration change, and never from the prescaler alone. A zero timeout, disabled monitors and a single-enable sweep show that the enable mapping is right and that no path raises a flag it should not. The recovery scenario clears a flag while the stall persists. It shows that the request is a single pulse per rising flag, and that detection re-arms with a full timeout.

// File: rtl/lockup_watchdog.sv
`timescale 1ns/1ps
module lockup_watchdog #(
  parameter int PRE_W    = 16,
  parameter int DMA_TO_W = 11,
  parameter int MAC_TO_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr_en,
  input  logic [PRE_W+DMA_TO_W+4:0] cfg_wr_data,
  output logic [PRE_W+DMA_TO_W+4:0] cfg_rd_data,
  input  logic [MAC_TO_W-1:0]      mac_timeout,
  input  logic [3:0]               busy,
  input  logic [3:0]               progress,
  input  logic [3:0]               lock_clr,
  output logic [3:0]               lock_flag,
  output logic                     mac_reset_req
);
  localparam int TO_LSB  = PRE_W;
  localparam int REC_BIT = PRE_W + DMA_TO_W;
  localparam int EN_LSB  = REC_BIT + 1;
  localparam int CFG_W   = EN_LSB + 4;
  localparam int CNT_W   = (DMA_TO_W > MAC_TO_W) ? DMA_TO_W : MAC_TO_W;
  localparam logic [CFG_W-1:0] CFG_RST = {5'b0, {DMA_TO_W{1'b1}}, {PRE_W{1'b1}}};

  logic [CFG_W-1:0] cfg;
  logic [PRE_W-1:0] pcnt;
  logic [3:0]       rise;

  wire [PRE_W-1:0]    presc   = cfg[PRE_W-1:0];
  wire [DMA_TO_W-1:0] dma_to  = cfg[REC_BIT-1:TO_LSB];
  wire                rec_en  = cfg[REC_BIT];
  wire [3:0]          en      = cfg[CFG_W-1:EN_LSB];
  wire                restart = cfg_wr_en && (cfg_wr_data[REC_BIT-1:0] != cfg[REC_BIT-1:0]);
  wire [PRE_W:0]      pinc    = {1'b0, pcnt} + 1'b1;
  wire                tick    = pinc >= {1'b0, presc};

  assign cfg_rd_data = cfg;

  always_ff @(posedge clk) begin
    if (!rst_n)         cfg <= CFG_RST;
    else if (cfg_wr_en) cfg <= cfg_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || tick) pcnt <= '0;
    else                           pcnt <= pinc[PRE_W-1:0];
  end

  for (genvar i = 0; i < 4; i++) begin : g_mon
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    if (i % 2 == 1) begin : g_dma
      assign lim = CNT_W'(dma_to);
    end else begin : g_mac
      assign lim = CNT_W'(mac_timeout);
    end
    wire           stall = en[i] & busy[i] & ~progress[i];
    wire [CNT_W:0] cinc  = {1'b0, cnt} + 1'b1;
    wire           hit   = stall & tick & (lim != '0) & (cinc >= {1'b0, lim});

    always_ff @(posedge clk) begin
      if (!rst_n || restart || !stall || hit) cnt <= '0;
      else if (tick)                          cnt <= cinc[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || lock_clr[i]) lock_flag[i] <= 1'b0;
      else if (hit)              lock_flag[i] <= 1'b1;
    end

    assign rise[i] = hit & ~lock_flag[i] & ~lock_clr[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mac_reset_req <= 1'b0;
    else        mac_reset_req <= rec_en & (|rise);
  end
endmodule

// File: rtl/lockup_watchdog_chk.sv
`timescale 1ns/1ps
module lockup_watchdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [31:0] cfg_rd_data,
  input logic [3:0]  busy,
  input logic [3:0]  progress,
  input logic [3:0]  lock_clr,
  input logic [3:0]  lock_flag,
  input logic        mac_reset_req
);
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr_en) |-> $stable(cfg_rd_data)); // R2
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_flag & ~$past(lock_flag)) & ~$past(cfg_rd_data[31:28])) == 4'b0); // R3
  AST_RISE_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_flag & ~$past(lock_flag)) & ~($past(busy) & ~$past(progress))) == 4'b0); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_flag) & ~lock_flag & ~$past(lock_clr)) == 4'b0); // R8
  AST_REQ_NEEDS_REC: assert property (@(posedge clk) disable iff (!rst_n)
    mac_reset_req |-> $past(cfg_rd_data[27])); // R9
  AST_REQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_reset_req |-> ((lock_flag & ~$past(lock_flag)) != 4'b0)); // R9
endmodule

bind lockup_watchdog lockup_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_data(cfg_rd_data),
  .busy(busy), .progress(progress), .lock_clr(lock_clr), .lock_flag(lock_flag),
  .mac_reset_req(mac_reset_req)
);

// File: tb/tb_lockup_watchdog.sv
`timescale 1ns/1ps
module tb_lockup_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic [15:0] mac_timeout = '0;
  logic [3:0]  busy = '0, progress = '0, lock_clr = '0;
  logic [3:0]  lock_flag;
  logic        mac_reset_req;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lockup_watchdog dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .mac_timeout(mac_timeout), .busy(busy),
    .progress(progress), .lock_clr(lock_clr), .lock_flag(lock_flag),
    .mac_reset_req(mac_reset_req)
  );

  function automatic logic [31:0] mk(input logic [3:0] en, input logic rec,
                                     input logic [10:0] to, input logic [15:0] pre);
    return {en, rec, to, pre};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); busy = '0; progress = '0; lock_clr = 4'hF;
    @(negedge clk); lock_clr = '0;
    cfg_write(32'h0);
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg_rd_data, 32'h07FF_FFFF);
    chk("R1 flags", {28'b0, lock_flag}, 32'h0);
    chk("R1 req", {31'b0, mac_reset_req}, 32'h0);
  endtask

  task automatic t_rw();
    cfg_write(32'h5A5A_1234);
    chk("R2 readback", cfg_rd_data, 32'h5A5A_1234);
    wait_n(3);
    chk("R2 hold", cfg_rd_data, 32'h5A5A_1234);
    settle();
  endtask

  task automatic t_dma(input logic [10:0] to, input logic [15:0] pre, input int edges);
    settle();
    busy = 4'b1000;
    cfg_write(mk(4'b1000, 1'b0, to, pre));
    wait_n(edges - 1);
    chk("R4 before timeout", {28'b0, lock_flag}, 32'h0);
    wait_n(1);
    chk("R4 at timeout", {28'b0, lock_flag}, 32'h8);
    chk("R9 no req when off", {31'b0, mac_reset_req}, 32'h0);
  endtask

  task automatic t_mac();
    settle();
    mac_timeout = 16'd2;
    busy = 4'b0001;
    cfg_write(mk(4'b0001, 1'b0, 11'd0, 16'd3));
    wait_n(5);
    chk("R5 before timeout", {28'b0, lock_flag}, 32'h0);
    wait_n(1);
    chk("R5 at timeout", {28'b0, lock_flag}, 32'h1);
  endtask

  task automatic t_interrupt(input bit use_idle);
    settle();
    busy = 4'b0010;
    cfg_write(mk(4'b0010, 1'b0, 11'd4, 16'd2));
    wait_n(5);
    if (use_idle) busy = 4'b0000; else progress = 4'b0010;
    wait_n(1);
    busy = 4'b0010; progress = 4'b0000;
    wait_n(7);
    chk(use_idle ? "R6 idle restart" : "R6 progress restart", {28'b0, lock_flag}, 32'h0);
    wait_n(1);
    chk("R6 late detect", {28'b0, lock_flag}, 32'h2);
  endtask

  task automatic t_zero();
    settle();
    mac_timeout = 16'd0;
    busy = 4'b1111;
    cfg_write(mk(4'b1111, 1'b1, 11'd0, 16'd1));
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (mac_reset_req !== 1'b0) chk("R7 no req", {31'b0, mac_reset_req}, 32'h0);
    end
    chk("R7 zero timeout", {28'b0, lock_flag}, 32'h0);
  endtask

  task automatic t_enables();
    settle();
    mac_timeout = 16'd1;
    busy = 4'b1111;
    cfg_write(mk(4'b0000, 1'b1, 11'd1, 16'd1));
    wait_n(30);
    chk("R3 all disabled", {28'b0, lock_flag}, 32'h0);
    settle();
    busy = 4'b1111;
    cfg_write(mk(4'b0100, 1'b0, 11'd1, 16'd1));
    wait_n(10);
    chk("R3 bit30 only tx MAC", {28'b0, lock_flag}, 32'h4);
  endtask

  task automatic t_recovery();
    settle();
    busy = 4'b1000;
    cfg_write(mk(4'b1000, 1'b1, 11'd3, 16'd4));
    wait_n(12);
    chk("R9 req pulse", {31'b0, mac_reset_req}, 32'h1);
    chk("R8 flag set", {28'b0, lock_flag}, 32'h8);
    wait_n(1);
    chk("R9 req one cycle", {31'b0, mac_reset_req}, 32'h0);
    chk("R8 flag sticky", {28'b0, lock_flag}, 32'h8);
    lock_clr = 4'b1000;
    wait_n(1);
    lock_clr = 4'b0000;
    chk("R8 cleared", {28'b0, lock_flag}, 32'h0);
    wait_n(9);
    chk("R8 before rearm", {28'b0, lock_flag}, 32'h0);
    wait_n(1);
    chk("R8 rearm detect", {28'b0, lock_flag}, 32'h8);
    chk("R9 second pulse", {31'b0, mac_reset_req}, 32'h1);
  endtask

  task automatic t_restart();
    settle();
    busy = 4'b1000;
    cfg_write(mk(4'b1000, 1'b0, 11'd3, 16'd4));
    wait_n(4);
    cfg_write(mk(4'b1000, 1'b0, 11'd4, 16'd4));
    wait_n(15);
    chk("R10 restart holds off", {28'b0, lock_flag}, 32'h0);
    wait_n(1);
    chk("R10 detect after restart", {28'b0, lock_flag}, 32'h8);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_rw();
    t_dma(11'd3, 16'd4, 12);
    t_dma(11'd5, 16'd0, 5);
    t_mac();
    t_interrupt(1'b0);
    t_interrupt(1'b1);
    t_zero();
    t_enables();
    t_recovery();
    t_restart();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule